// File: doc/BRIEF.md
# Configuration Reload Sequencer

This block re-runs the configuration load chain of a power-management device while it is running. Software writes an 8-bit reload mask. Each of five stage bits in the mask enables one step of the chain, and the top bit starts the run. The block then sends a one-clock strobe to each enabled stage, one stage per clock. The stages always run in the same order: fuse latch, ECC check state, shadow registers, power-control registers and power-button configuration. Stages whose bit is clear are skipped.

A separate one-bit power-cycle register decides whether a software-started run first raises a turn-off request. When it is set, the turn-off request is held for a fixed number of cycles before the stages begin. A turn-on event from the power button also starts a run. That run covers all five stages, with no forced power-control update and no turn-off.

While a run is in progress, the block reports busy and ignores every write and every button event. When the run ends, it raises a one-cycle done pulse and clears the start bit in the mask.

Top module: `cfg_reload_seq`

## Requirements
- R1: After a synchronous reset, the mask reads 0x00 and the power-cycle bit reads 0. Busy, done, turn-off request and every strobe are low.
- R2: When idle, a write with `cfg_wr_sel`=0 stores all 8 data bits in the mask, and a write with `cfg_wr_sel`=1 stores data bit 0 as the power-cycle bit. A mask write with bit 7 clear starts nothing.
- R3: A mask write with bit 7 set starts a run. The mask bits map to stages as follows: bit 1 is the fuse latch, bit 2 the ECC reload, bit 3 the shadow reload, bit 4 the power-control reload and bit 6 the button configuration. Enabled stages strobe one per clock in that order, and at most one strobe is high at a time. Without a power cycle, the first strobe appears in the cycle after the write is accepted.
- R4: `pwrctl_force` pulses together with the power-control strobe only when mask bits 4 and 5 are both set. Bit 5 alone has no effect.
- R5: `shadow_corrected` pulses together with the shadow strobe only when `ecc_enable` is high, which selects corrected values over raw fuse values.
- R6: When the power-cycle bit is 1, a started run holds `off_req` high for OFF_CYCLES cycles, beginning in the cycle after the start. No strobe appears while `off_req` is high. The first strobe follows one cycle after `off_req` falls.
- R7: `done` pulses for one cycle in the cycle after the last strobe, or after the start when no stage is enabled. Busy falls in that same cycle, and mask bit 7 reads 0 from then on while bits 6..0 keep their written value.
- R8: While busy, writes to either register and button events have no effect, and the run in progress is not altered.
- R9: When idle, a `btn_turn_on` pulse starts a run of all five stages with no force and no turn-off, and leaves the mask unchanged.
- R10: When a mask write and a button event arrive in the same idle cycle, the write wins and only its selected stages run.
- R11: Mask bit 0 is reserved. It is stored, but it enables no stage and has no effect on a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0 selects the reload mask, 1 selects the power-cycle register |
| cfg_wr_data | input | 8 | Write data |
| btn_turn_on | input | 1 | Power-button turn-on event pulse |
| ecc_enable | input | 1 | ECC correction is on |
| stb_fuse_latch | output | 1 | Stage strobe: latch fuse values |
| stb_ecc_reload | output | 1 | Stage strobe: reload ECC check state |
| stb_shadow_reload | output | 1 | Stage strobe: reload shadow registers |
| shadow_corrected | output | 1 | Shadow reload uses corrected values |
| stb_pwrctl_reload | output | 1 | Stage strobe: reload power-control registers |
| pwrctl_force | output | 1 | Power-control reload takes effect immediately |
| stb_button_cfg | output | 1 | Stage strobe: switch button configuration now |
| off_req | output | 1 | Momentary turn-off request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mask_q | output | 8 | Current reload mask |
| pwr_cycle_q | output | 1 | Current power-cycle bit |

## Verification
The main function is driven with all 64 combinations of mask bits 6..1, each run once without and once with the power cycle. The reserved bit and `ecc_enable` vary across the sweep. This sweep separates stage mapping and ordering errors, failures to skip disabled stages, a force that ignores bit 4, and off-by-one counts in the turn-off window. Directed patterns cover a start with only the reserved bit set, a write without the start bit, a button-only run, a write and a button event in the same cycle, and writes and a button event arriving during a long run. These show whether each trigger is accepted or ignored, and whether the run that follows is the right one.

// File: rtl/reload_seq_pkg.sv
package reload_seq_pkg;

  localparam int REG_W      = 8;
  localparam int NUM_STAGES = 5;

  // stage positions in the strobe vector (run order)
  localparam int STG_FUSE   = 0;
  localparam int STG_ECC    = 1;
  localparam int STG_SHADOW = 2;
  localparam int STG_PWRCTL = 3;
  localparam int STG_BUTTON = 4;

  // mask bit positions
  localparam int MB_FUSE   = 1;
  localparam int MB_ECC    = 2;
  localparam int MB_SHADOW = 3;
  localparam int MB_PWRCTL = 4;
  localparam int MB_FORCE  = 5;
  localparam int MB_BUTTON = 6;
  localparam int MB_START  = 7;

  localparam logic [NUM_STAGES-1:0] ALL_STAGES = '1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_OFF, SEQ_RUN} seq_state_t;

  function automatic logic [NUM_STAGES-1:0] stages_from_mask(input logic [REG_W-1:0] m);
    logic [NUM_STAGES-1:0] s;
    s[STG_FUSE]   = m[MB_FUSE];
    s[STG_ECC]    = m[MB_ECC];
    s[STG_SHADOW] = m[MB_SHADOW];
    s[STG_PWRCTL] = m[MB_PWRCTL];
    s[STG_BUTTON] = m[MB_BUTTON];
    return s;
  endfunction

endpackage

// File: rtl/reload_cfg_regs.sv
module reload_cfg_regs
  import reload_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  input  logic             clr_start,
  output logic [REG_W-1:0] mask_q,
  output logic             pwr_cycle_q,
  output logic             start_req
);

  logic wr_ok;
  assign wr_ok     = wr_en && !busy;
  assign start_req = wr_ok && !wr_sel && wr_data[MB_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '0;
      pwr_cycle_q <= 1'b0;
    end else begin
      if (wr_ok && !wr_sel)
        mask_q <= wr_data;
      else if (clr_start)
        mask_q[MB_START] <= 1'b0;
      if (wr_ok && wr_sel)
        pwr_cycle_q <= wr_data[0];
    end
  end

  AST_MASK_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> (mask_q[MB_START-1:0] == $past(mask_q[MB_START-1:0]))
                        && (pwr_cycle_q == $past(pwr_cycle_q))); // R8

endmodule

// File: rtl/reload_lowest_pick.sv
module reload_lowest_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  logic [N-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i] = req[i] & ~seen[i];
    if (i < N-1) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
    end
  end

endmodule

// File: rtl/reload_ctrl.sv
module reload_ctrl
  import reload_seq_pkg::*;
#(
  parameter int OFF_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mask_start,
  input  logic [NUM_STAGES-1:0] mask_stages,
  input  logic                  mask_force,
  input  logic                  pwr_cycle,
  input  logic                  btn_event,
  input  logic                  ecc_on,
  output logic [NUM_STAGES-1:0] stb_q,
  output logic                  force_q,
  output logic                  corr_q,
  output logic                  off_req_q,
  output logic                  busy_q,
  output logic                  done_q,
  output logic                  finish
);

  localparam int OFF_W = $clog2(OFF_CYCLES + 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_CYCLES - 1);

  seq_state_t            state;
  logic [NUM_STAGES-1:0] pend;
  logic [NUM_STAGES-1:0] grant;
  logic [OFF_W-1:0]      off_cnt;
  logic                  keep_force;

  reload_lowest_pick #(.N(NUM_STAGES)) i_pick (
    .req   (pend),
    .grant (grant)
  );

  assign finish = (state == SEQ_RUN) && (pend == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      pend       <= '0;
      off_cnt    <= '0;
      keep_force <= 1'b0;
      stb_q      <= '0;
      force_q    <= 1'b0;
      corr_q     <= 1'b0;
      off_req_q  <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      stb_q   <= '0;
      force_q <= 1'b0;
      corr_q  <= 1'b0;
      done_q  <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (mask_start) begin
            pend       <= mask_stages;
            keep_force <= mask_force;
            busy_q     <= 1'b1;
            if (pwr_cycle) begin
              state     <= SEQ_OFF;
              off_req_q <= 1'b1;
              off_cnt   <= '0;
            end else begin
              state <= SEQ_RUN;
            end
          end else if (btn_event) begin
            pend       <= ALL_STAGES;
            keep_force <= 1'b0;
            busy_q     <= 1'b1;
            state      <= SEQ_RUN;
          end
        end
        SEQ_OFF: begin
          if (off_cnt == OFF_LAST) begin
            off_req_q <= 1'b0;
            state     <= SEQ_RUN;
          end else begin
            off_cnt <= off_cnt + 1'b1;
          end
        end
        SEQ_RUN: begin
          if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= SEQ_IDLE;
          end else begin
            stb_q   <= grant;
            pend    <= pend & ~grant;
            force_q <= grant[STG_PWRCTL] & keep_force;
            corr_q  <= grant[STG_SHADOW] & ecc_on;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (stb_q == '0 && !off_req_q)); // R3
  AST_FORCE_WITH_PWRCTL: assert property (@(posedge clk) disable iff (rst)
    force_q |-> stb_q[STG_PWRCTL]); // R4
  AST_CORR_WITH_SHADOW: assert property (@(posedge clk) disable iff (rst)
    corr_q |-> stb_q[STG_SHADOW]); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    off_req_q |-> (stb_q == '0)); // R6
  AST_OFF_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(off_req_q) |-> !$past(busy_q)); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R7
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q); // R7

endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq
  import reload_seq_pkg::*;
#(
  parameter int OFF_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr_en,
  input  logic       cfg_wr_sel,
  input  logic [7:0] cfg_wr_data,
  input  logic       btn_turn_on,
  input  logic       ecc_enable,
  output logic       stb_fuse_latch,
  output logic       stb_ecc_reload,
  output logic       stb_shadow_reload,
  output logic       shadow_corrected,
  output logic       stb_pwrctl_reload,
  output logic       pwrctl_force,
  output logic       stb_button_cfg,
  output logic       off_req,
  output logic       busy,
  output logic       done,
  output logic [7:0] mask_q,
  output logic       pwr_cycle_q
);

  logic                  start_req;
  logic                  finish;
  logic [NUM_STAGES-1:0] stb;

  reload_cfg_regs i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .wr_sel      (cfg_wr_sel),
    .wr_data     (cfg_wr_data),
    .busy        (busy),
    .clr_start   (finish),
    .mask_q      (mask_q),
    .pwr_cycle_q (pwr_cycle_q),
    .start_req   (start_req)
  );

  reload_ctrl #(.OFF_CYCLES(OFF_CYCLES)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mask_start  (start_req),
    .mask_stages (stages_from_mask(cfg_wr_data)),
    .mask_force  (cfg_wr_data[MB_FORCE]),
    .pwr_cycle   (pwr_cycle_q),
    .btn_event   (btn_turn_on),
    .ecc_on      (ecc_enable),
    .stb_q       (stb),
    .force_q     (pwrctl_force),
    .corr_q      (shadow_corrected),
    .off_req_q   (off_req),
    .busy_q      (busy),
    .done_q      (done),
    .finish      (finish)
  );

  assign stb_fuse_latch    = stb[STG_FUSE];
  assign stb_ecc_reload    = stb[STG_ECC];
  assign stb_shadow_reload = stb[STG_SHADOW];
  assign stb_pwrctl_reload = stb[STG_PWRCTL];
  assign stb_button_cfg    = stb[STG_BUTTON];

  AST_START_CLEARED: assert property (@(posedge clk) disable iff (rst)
    done |-> !mask_q[MB_START]); // R7

endmodule

// File: tb/test_cfg_reload_seq.sv
module test_cfg_reload_seq;

  localparam int CLK_PERIOD = 10;
  localparam int OFFC       = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic       cfg_wr_sel = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       btn_turn_on = 1'b0;
  logic       ecc_enable = 1'b0;
  logic       stb_fuse_latch, stb_ecc_reload, stb_shadow_reload, shadow_corrected;
  logic       stb_pwrctl_reload, pwrctl_force, stb_button_cfg;
  logic       off_req, busy, done, pwr_cycle_q;
  logic [7:0] mask_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_reload_seq #(.OFF_CYCLES(OFFC)) i_cfg_reload_seq (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .btn_turn_on(btn_turn_on), .ecc_enable(ecc_enable),
    .stb_fuse_latch(stb_fuse_latch), .stb_ecc_reload(stb_ecc_reload),
    .stb_shadow_reload(stb_shadow_reload), .shadow_corrected(shadow_corrected),
    .stb_pwrctl_reload(stb_pwrctl_reload), .pwrctl_force(pwrctl_force),
    .stb_button_cfg(stb_button_cfg), .off_req(off_req), .busy(busy), .done(done),
    .mask_q(mask_q), .pwr_cycle_q(pwr_cycle_q)
  );

  // observed order: off, busy, done, button, pwrctl, force, shadow, corr, ecc, fuse
  function automatic logic [9:0] obs();
    return {off_req, busy, done, stb_button_cfg, stb_pwrctl_reload, pwrctl_force,
            stb_shadow_reload, shadow_corrected, stb_ecc_reload, stb_fuse_latch};
  endfunction

  function automatic logic [9:0] mk(input logic o, input logic b, input logic d,
                                    input logic [4:0] s, input logic f, input logic c);
    return {o, b, d, s[4], s[3], f, s[2], c, s[1], s[0]};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] data);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic press_button();
    btn_turn_on = 1'b1;
    @(negedge clk);
    btn_turn_on = 1'b0;
  endtask

  // called at the negedge right after the start edge
  task automatic run_seq(input string tag, input logic [4:0] en, input logic frc,
                         input int d, input logic ecc);
    int k;
    k = $countones(en);
    check(tag, obs(), mk(d > 0, 1'b1, 1'b0, 5'b0, 1'b0, 1'b0));
    for (int j = 1; j <= d + k + 1; j++) begin
      logic [9:0] e;
      @(negedge clk);
      if (j < d)       e = mk(1'b1, 1'b1, 1'b0, 5'b0, 1'b0, 1'b0);
      else if (j == d) e = mk(1'b0, 1'b1, 1'b0, 5'b0, 1'b0, 1'b0);
      else begin
        int p;
        p = j - d;
        if (p <= k) begin
          int cnt;
          int sel;
          cnt = 0; sel = 0;
          for (int s = 0; s < 5; s++)
            if (en[s]) begin
              cnt++;
              if (cnt == p) sel = s;
            end
          e = mk(1'b0, 1'b1, 1'b0, 5'(1 << sel), (sel == 3) && frc, (sel == 2) && ecc);
        end else begin
          e = mk(1'b0, 1'b0, 1'b1, 5'b0, 1'b0, 1'b0);
        end
      end
      check(tag, obs(), e);
    end
    @(negedge clk);
    check(tag, obs(), '0);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 200000; wd++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", obs(), '0);
    check8("R1 mask", mask_q, 8'h00);
    check8("R1 pwr_cycle", {7'b0, pwr_cycle_q}, 8'h00);

    // R2 write without start bit
    do_write(1'b0, 8'h7E);
    check8("R2 mask stored", mask_q, 8'h7E);
    for (int i = 0; i < 3; i++) begin
      check("R2 no run", obs(), '0);
      @(negedge clk);
    end

    // R11 reserved bit alone with start
    do_write(1'b0, 8'h81);
    run_seq("R11 reserved only", 5'b00000, 1'b0, 0, 1'b0);
    check8("R11 mask after", mask_q, 8'h01);

    // R10 write and button together
    btn_turn_on = 1'b1;
    do_write(1'b0, 8'h84);
    btn_turn_on = 1'b0;
    run_seq("R10 write wins", 5'b00010, 1'b0, 0, 1'b0);

    // R9 button alone
    ecc_enable = 1'b1;
    press_button();
    run_seq("R9 button full run", 5'b11111, 1'b0, 0, 1'b1);
    check8("R9 mask unchanged", mask_q, 8'h04);

    // sweep: R3 R4 R5 R6 R7 R11
    for (int pc = 0; pc < 2; pc++) begin
      do_write(1'b1, 8'(pc));
      check8("R2 pwr_cycle stored", {7'b0, pwr_cycle_q}, 8'(pc));
      for (int m = 0; m < 64; m++) begin
        logic [7:0] data;
        logic [4:0] en;
        data = {1'b1, 6'(m), 1'(m[2] ^ pc[0])};
        en = {1'(m[5]), 1'(m[3]), 1'(m[2]), 1'(m[1]), 1'(m[0])};
        ecc_enable = m[1] ^ m[4] ^ pc[0];
        do_write(1'b0, data);
        run_seq("R3 R4 R5 R6 R7 sweep", en, 1'(m[4]), (pc == 1) ? OFFC : 0, ecc_enable);
        check8("R7 start bit cleared", mask_q, data & 8'h7F);
      end
    end

    // R8 writes and button during busy
    do_write(1'b1, 8'h01);
    do_write(1'b0, 8'h82);
    do_write(1'b0, 8'hFE);
    do_write(1'b1, 8'h00);
    press_button();
    @(negedge clk);
    check("R8 off ends", obs(), mk(1'b0, 1'b1, 1'b0, 5'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R8 fuse stage", obs(), mk(1'b0, 1'b1, 1'b0, 5'b00001, 1'b0, 1'b0));
    @(negedge clk);
    check("R8 done", obs(), mk(1'b0, 1'b0, 1'b1, 5'b0, 1'b0, 1'b0));
    check8("R8 mask kept", mask_q, 8'h02);
    check8("R8 pwr_cycle kept", {7'b0, pwr_cycle_q}, 8'h01);
    @(negedge clk);
    check("R8 no extra run", obs(), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule